// File: doc/BRIEF.md
# x86 Legacy Prefix Scanner

This block sits at the head of an x86 instruction decoder. It takes the instruction stream one byte per cycle over a valid/ready stream and sorts each legacy prefix byte into one of four group slots: lock/repeat, segment, operand size and address size. The first byte that is not a prefix is taken as the opcode. One cycle later the block emits a single-cycle result strobe. The strobe carries the opcode byte, the resolved lock/repeat code, the segment override, an optional branch hint, the effective operand and address sizes and the number of prefix bytes seen. The block then starts the next instruction with empty slots.

Repeated or conflicting prefixes are resolved per group. In the lock/repeat group and the segment group, the latest byte replaces the earlier one. Repeats of the size overrides behave as a single occurrence. The block also enforces a maximum instruction length. If the byte that would be the opcode lands past that length, the block pulses a fault instead of a result and drops everything it has collected.

Top module: `x86pfx_scan`

## Requirements
- R1: While the synchronous reset is high, the slots and the prefix counter are cleared. After reset, `out_valid` and `out_fault` are 0, and the next opcode is reported with no prefixes.
- R2: F0h, F2h and F3h share one slot, and the latest of them wins. `out_grp1` encodes this slot as 0 = none, 1 = LOCK (F0h), 2 = repeat-while-not-equal (F2h), 3 = repeat (F3h).
- R3: 26h, 2Eh, 36h, 3Eh, 64h and 65h share one slot, and the latest of them wins. `out_seg` encodes this slot as 0 = none, 1 = ES (26h), 2 = CS (2Eh), 3 = SS (36h), 4 = DS (3Eh), 5 = FS (64h), 6 = GS (65h).
- R4: `out_op32` is `mode32` inverted if at least one 66h was seen. `out_addr32` is `mode32` inverted if at least one 67h was seen. Any number of repeats acts as one.
- R5: Prefixes may come in any order and mixed across groups. `out_npfx` reports the number of prefix bytes that came before the opcode.
- R6: A non-prefix byte accepted at a clock edge makes `out_valid` high for exactly the following cycle. In that cycle `out_opcode` holds the byte. The next instruction starts with empty slots.
- R7: A short conditional jump is an opcode from 70h to 7Fh. If the opcode is a short conditional jump and the segment slot holds 2Eh or 3Eh, then `out_seg` is 0 and `out_hint` is 2 (not taken, 2Eh) or 3 (taken, 3Eh). In every other case `out_hint` is 0.
- R8: Suppose a byte of any kind is accepted while MAX_LEN (15) prefixes are already held. This is the byte in position 16. Then `out_fault` pulses for one cycle, `out_valid` stays low and all slots are discarded. The byte after it starts a new instruction.
- R9: A cycle with `in_valid` low changes no slot or count, and raises neither `out_valid` nor `out_fault` in the following cycle.
- R10: `in_ready` is 1 whenever reset is low, and 0 while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mode32 | input | 1 | Default size: 1 = 32-bit, 0 = 16-bit |
| out_valid | output | 1 | One-cycle result strobe |
| out_fault | output | 1 | One-cycle over-length fault pulse |
| out_opcode | output | 8 | First non-prefix byte |
| out_grp1 | output | 2 | Lock/repeat code (R2) |
| out_seg | output | 3 | Segment override code (R3) |
| out_hint | output | 2 | Branch hint code (R7) |
| out_op32 | output | 1 | Effective operand size is 32-bit |
| out_addr32 | output | 1 | Effective address size is 32-bit |
| out_npfx | output | CW (4) | Number of prefix bytes |

## Verification
Three pairs of functions can meet in one cycle.

The first pair is the length limit and the opcode strobe. The 16th byte can be a non-prefix byte, which would otherwise produce a result. The bench sends 15 prefixes followed by such a byte and expects a fault with no strobe. It also sends 14 prefixes followed by an opcode and expects a normal result reporting 14 prefixes.

The second pair is the segment slot and the branch-hint decoding. A 2Eh or 3Eh ahead of a 70h–7Fh opcode must become a hint, and the same bytes ahead of any other opcode must stay segment overrides.

The third pair is the clearing after a result and the first prefix of the next instruction. Instructions are sent back to back with no idle cycle between them. A behavioural model compares every output on every cycle.

// File: rtl/x86pfx_pkg.sv
package x86pfx_pkg;

   typedef enum logic [1:0] {G1_NONE, G1_LOCK, G1_REPNE, G1_REP} grp1_e;

   typedef enum logic [2:0] {
      SEG_NONE, SEG_ES, SEG_CS, SEG_SS, SEG_DS, SEG_FS, SEG_GS, SEG_RSV
   } seg_e;

   typedef enum logic [1:0] {PG_LKREP, PG_SEG, PG_OPSZ, PG_ADSZ} pgroup_e;

   typedef struct packed {
      logic    is_pfx;
      pgroup_e grp;
      grp1_e   g1;
      seg_e    seg;
   } pclass_t;

endpackage

// File: rtl/x86pfx_classify.sv
module x86pfx_classify
   import x86pfx_pkg::*;
(
   input  logic [7:0] byte_i,
   output pclass_t    cls_o
);

   always_comb begin
      cls_o = '{is_pfx: 1'b1, grp: PG_LKREP, g1: G1_NONE, seg: SEG_NONE};
      unique case (byte_i)
         8'hF0:   cls_o.g1  = G1_LOCK;
         8'hF2:   cls_o.g1  = G1_REPNE;
         8'hF3:   cls_o.g1  = G1_REP;
         8'h26:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_ES; end
         8'h2E:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_CS; end
         8'h36:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_SS; end
         8'h3E:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_DS; end
         8'h64:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_FS; end
         8'h65:   begin cls_o.grp = PG_SEG; cls_o.seg = SEG_GS; end
         8'h66:   cls_o.grp = PG_OPSZ;
         8'h67:   cls_o.grp = PG_ADSZ;
         default: cls_o.is_pfx = 1'b0;
      endcase
   end

endmodule

// File: rtl/x86pfx_slots.sv
module x86pfx_slots
   import x86pfx_pkg::*;
#(
   parameter int MAX_LEN = 15,
   localparam int CW = $clog2(MAX_LEN + 1)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          take_i,
   input  logic          clr_i,
   input  pclass_t       cls_i,
   output grp1_e         g1_o,
   output seg_e          seg_o,
   output logic          op_seen_o,
   output logic          ad_seen_o,
   output logic [CW-1:0] cnt_o,
   output logic          full_o
);

   assign full_o = (cnt_o == CW'(MAX_LEN));

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         g1_o      <= G1_NONE;
         seg_o     <= SEG_NONE;
         op_seen_o <= 1'b0;
         ad_seen_o <= 1'b0;
         cnt_o     <= '0;
      end else if (take_i) begin
         cnt_o <= cnt_o + CW'(1);
         unique case (cls_i.grp)
            PG_LKREP: g1_o      <= cls_i.g1;
            PG_SEG:   seg_o     <= cls_i.seg;
            PG_OPSZ:  op_seen_o <= 1'b1;
            PG_ADSZ:  ad_seen_o <= 1'b1;
         endcase
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_o <= CW'(MAX_LEN)); // R5
   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (cnt_o == '0) && !op_seen_o && !ad_seen_o); // R6
   AST_OPSZ_STICKY: assert property (@(posedge clk) disable iff (rst)
      (take_i && !clr_i && cls_i.grp == PG_OPSZ) |=> op_seen_o); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!take_i && !clr_i) |=> $stable(cnt_o) && $stable(seg_o) && $stable(g1_o)); // R9

endmodule

// File: rtl/x86pfx_resolve.sv
module x86pfx_resolve
   import x86pfx_pkg::*;
#(
   parameter bit HINT_EN = 1'b1
)(
   input  logic [7:0] opcode_i,
   input  logic       mode32_i,
   input  seg_e       seg_i,
   input  logic       op_seen_i,
   input  logic       ad_seen_i,
   output seg_e       seg_o,
   output logic [1:0] hint_o,
   output logic       op32_o,
   output logic       addr32_o
);

   logic is_jcc;

   generate
      if (HINT_EN) begin : g_hint
         assign is_jcc = (opcode_i[7:4] == 4'h7);
      end else begin : g_nohint
         assign is_jcc = 1'b0;
      end
   endgenerate

   always_comb begin
      seg_o  = seg_i;
      hint_o = 2'b00;
      if (is_jcc && seg_i == SEG_CS) begin
         seg_o  = SEG_NONE;
         hint_o = 2'b10;
      end else if (is_jcc && seg_i == SEG_DS) begin
         seg_o  = SEG_NONE;
         hint_o = 2'b11;
      end
   end

   assign op32_o   = mode32_i ^ op_seen_i;
   assign addr32_o = mode32_i ^ ad_seen_i;

endmodule

// File: rtl/x86pfx_scan.sv
module x86pfx_scan
   import x86pfx_pkg::*;
#(
   parameter int MAX_LEN = 15,
   parameter bit HINT_EN = 1'b1,
   localparam int CW = $clog2(MAX_LEN + 1)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   output logic          in_ready,
   input  logic          mode32,
   output logic          out_valid,
   output logic          out_fault,
   output logic [7:0]    out_opcode,
   output logic [1:0]    out_grp1,
   output logic [2:0]    out_seg,
   output logic [1:0]    out_hint,
   output logic          out_op32,
   output logic          out_addr32,
   output logic [CW-1:0] out_npfx
);

   generate
      if (MAX_LEN < 2 || MAX_LEN > 255) begin : g_bad_len
         $error("x86pfx_scan: MAX_LEN must lie in 2..255");
      end
   endgenerate

   pclass_t       cls;
   grp1_e         s_g1;
   seg_e          s_seg, r_seg;
   logic          s_op, s_ad, s_full;
   logic [CW-1:0] s_cnt;
   logic [1:0]    r_hint;
   logic          r_op32, r_ad32;
   logic          acc, take, clr;

   assign in_ready = ~rst;
   assign acc      = in_valid & in_ready;
   assign take     = acc & cls.is_pfx & ~s_full;
   assign clr      = acc & (s_full | ~cls.is_pfx);

   x86pfx_classify u_cls (
      .byte_i (in_byte),
      .cls_o  (cls)
   );

   x86pfx_slots #(.MAX_LEN(MAX_LEN)) u_slots (
      .clk       (clk),
      .rst       (rst),
      .take_i    (take),
      .clr_i     (clr),
      .cls_i     (cls),
      .g1_o      (s_g1),
      .seg_o     (s_seg),
      .op_seen_o (s_op),
      .ad_seen_o (s_ad),
      .cnt_o     (s_cnt),
      .full_o    (s_full)
   );

   x86pfx_resolve #(.HINT_EN(HINT_EN)) u_res (
      .opcode_i  (in_byte),
      .mode32_i  (mode32),
      .seg_i     (s_seg),
      .op_seen_i (s_op),
      .ad_seen_i (s_ad),
      .seg_o     (r_seg),
      .hint_o    (r_hint),
      .op32_o    (r_op32),
      .addr32_o  (r_ad32)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_fault  <= 1'b0;
         out_opcode <= '0;
         out_grp1   <= '0;
         out_seg    <= '0;
         out_hint   <= '0;
         out_op32   <= 1'b0;
         out_addr32 <= 1'b0;
         out_npfx   <= '0;
      end else begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         if (acc && s_full) begin
            out_fault <= 1'b1;
         end else if (acc && !cls.is_pfx) begin
            out_valid  <= 1'b1;
            out_opcode <= in_byte;
            out_grp1   <= s_g1;
            out_seg    <= r_seg;
            out_hint   <= r_hint;
            out_op32   <= r_op32;
            out_addr32 <= r_ad32;
            out_npfx   <= s_cnt;
         end
      end
   end

   AST_FAULT_ON_OVER: assert property (@(posedge clk) disable iff (rst)
      (in_valid && s_full) |=> out_fault && !out_valid); // R8
   AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_fault)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && !out_fault); // R9
   AST_HINT_NOSEG: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_hint[1]) |-> out_seg == 3'd0); // R7
   AST_HINT_JCC: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_hint != 2'b00) |-> out_opcode[7:4] == 4'h7); // R7
   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !in_valid) |=> !out_valid); // R6

endmodule

// File: tb/x86pfx_scan_tb.sv
module x86pfx_scan_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       mode32 = 1'b1;
   logic       in_ready, out_valid, out_fault, out_op32, out_addr32;
   logic [7:0] out_opcode;
   logic [1:0] out_grp1, out_hint;
   logic [2:0] out_seg;
   logic [3:0] out_npfx;

   int n_chk = 0;
   int n_err = 0;
   bit started = 1'b0;

   always #2 clk = ~clk;

   x86pfx_scan u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .mode32(mode32), .out_valid(out_valid),
      .out_fault(out_fault), .out_opcode(out_opcode), .out_grp1(out_grp1),
      .out_seg(out_seg), .out_hint(out_hint), .out_op32(out_op32),
      .out_addr32(out_addr32), .out_npfx(out_npfx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_cnt = 0, m_g1 = 0, m_seg = 0;
   bit m_op = 0, m_ad = 0;
   bit e_valid = 0, e_fault = 0, e_idle = 0;
   int e_opc = 0, e_g1 = 0, e_seg = 0, e_hint = 0, e_op32 = 0, e_ad32 = 0, e_cnt = 0;

   function automatic void m_clear();
      m_cnt = 0; m_g1 = 0; m_seg = 0; m_op = 0; m_ad = 0;
   endfunction

   always @(negedge clk) begin
      if (started) begin
         chk("R10 ready", int'(in_ready), int'(!rst));
         chk("R6 valid", int'(out_valid), int'(e_valid));
         chk("R8 fault", int'(out_fault), int'(e_fault));
         if (e_idle) chk("R9 idle", int'(out_valid | out_fault), 0);
         if (e_valid && out_valid) begin
            chk("R6 opcode", int'(out_opcode), e_opc);
            chk("R2 grp1", int'(out_grp1), e_g1);
            chk("R3 seg", int'(out_seg), e_seg);
            chk("R7 hint", int'(out_hint), e_hint);
            chk("R4 op32", int'(out_op32), e_op32);
            chk("R4 addr32", int'(out_addr32), e_ad32);
            chk("R5 count", int'(out_npfx), e_cnt);
         end
      end
      e_valid = 0; e_fault = 0; e_idle = 0;
      if (rst) begin
         m_clear();
      end else if (!in_valid) begin
         e_idle = 1;
      end else if (m_cnt == 15) begin
         e_fault = 1;
         m_clear();
      end else begin
         case (in_byte)
            8'hF0: begin m_g1 = 1; m_cnt++; end
            8'hF2: begin m_g1 = 2; m_cnt++; end
            8'hF3: begin m_g1 = 3; m_cnt++; end
            8'h26: begin m_seg = 1; m_cnt++; end
            8'h2E: begin m_seg = 2; m_cnt++; end
            8'h36: begin m_seg = 3; m_cnt++; end
            8'h3E: begin m_seg = 4; m_cnt++; end
            8'h64: begin m_seg = 5; m_cnt++; end
            8'h65: begin m_seg = 6; m_cnt++; end
            8'h66: begin m_op = 1; m_cnt++; end
            8'h67: begin m_ad = 1; m_cnt++; end
            default: begin
               e_valid = 1;
               e_opc = in_byte; e_g1 = m_g1; e_seg = m_seg; e_hint = 0;
               e_cnt = m_cnt;
               e_op32 = int'(mode32 ^ m_op);
               e_ad32 = int'(mode32 ^ m_ad);
               if (in_byte >= 8'h70 && in_byte <= 8'h7F && m_seg == 2) begin
                  e_hint = 2; e_seg = 0;
               end else if (in_byte >= 8'h70 && in_byte <= 8'h7F && m_seg == 4) begin
                  e_hint = 3; e_seg = 0;
               end
               m_clear();
            end
         endcase
      end
   end

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
         in_byte  = 8'hFF;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      started = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset fault", int'(out_fault), 0);
      // R6 plain opcode, both default sizes
      send(8'h90); mode32 = 1'b0; send(8'h8B); mode32 = 1'b1; idle(1);
      // R2 last lock/repeat wins
      send(8'hF3); send(8'hF2); send(8'hA6);
      send(8'hF0); send(8'hF3); send(8'hA4);
      send(8'hF2); send(8'hF0); send(8'h01);
      // R3 last segment wins, gaps between bytes
      send(8'h26); idle(2); send(8'h64); send(8'h8B);
      send(8'h65); send(8'h36); send(8'h3E); send(8'h26); send(8'h8A);
      // R4 repeated size overrides, both modes
      send(8'h66); send(8'h66); send(8'h66); send(8'h89);
      mode32 = 1'b0;
      send(8'h67); send(8'h67); send(8'h66); send(8'h8B);
      mode32 = 1'b1;
      // R5 mixed order
      send(8'h67); send(8'h2E); send(8'hF0); send(8'h66); send(8'h01);
      // R7 hints vs overrides
      send(8'h2E); send(8'h74);
      send(8'h3E); send(8'h7F);
      send(8'h2E); send(8'h8B);
      send(8'h64); send(8'h3E); send(8'h70);
      send(8'h26); send(8'h75);
      // R8 boundary: 14 prefixes then opcode is fine
      for (int i = 0; i < 14; i++) send((i % 2) ? 8'h66 : 8'hF3);
      send(8'hAF);
      // R8 15 prefixes then opcode byte faults
      for (int i = 0; i < 15; i++) send(8'h26);
      send(8'h90);
      send(8'h90);
      // R8 16th byte is itself a prefix
      for (int i = 0; i < 15; i++) send(8'h67);
      send(8'h66);
      send(8'h8B);
      // R1 reset mid-instruction
      send(8'hF0); send(8'h65);
      @(posedge clk); #1 in_valid = 1'b0; rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      send(8'h8B);
      idle(3);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule